// File: doc/BRIEF.md
# Radix-2 Complex Butterfly with Run-Time Decimation Select

This block computes one radix-2 butterfly per clock for a fixed-point FFT or inverse FFT engine. Each accepted beat carries an even sample, an odd sample and a twiddle factor, all complex with signed 16-bit real and imaginary parts, along with three control bits. The control bits choose decimation-in-time or decimation-in-frequency ordering, choose forward or inverse direction, and turn on a halving step for that stage. The two complex results come out three cycles later with a valid flag that stays aligned to them. The control bits travel with the data, so neighbouring beats may use different settings.

In time-decimation order the odd sample is rotated by the twiddle first, and the outputs are the even sample plus and minus that rotated value. In frequency-decimation order the sum and the difference of the two samples are formed first, and only the difference is rotated. Twiddles are Q1.15 values of the form exp(-j·π·k/n), where n is the number of interleaved butterflies in the stage. For an inverse transform the twiddle's imaginary part is negated before use. Addressing, bit reversal and stage sequencing are handled outside this block.

Top module: `fft_bfly_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock edges. Every beat presented with `in_valid` high produces one result beat, and idle cycles produce no result beat.
- R2: With `dif_sel` low, the rotated value is m = b·w. The outputs are x = a + m and y = a − m.
- R3: With `dif_sel` high, the outputs are x = a + b and y = (a − b)·w.
- R4: With `inv_sel` high, w_im is negated before the complex multiply. A w_im of −32768 becomes +32768 exactly, without wrapping.
- R5: Each complex product component is computed as the exact sum of two signed products. It is then rounded to Q0 by adding 2^14 and shifting right arithmetically by 15, which is round-half-up. Example: b = 1, w_re = 16384 gives m_re = 1, and w_re = 16383 gives m_re = 0.
- R6: With `halve_en` high, every output component v becomes (v + 1) >> 1, with an arithmetic shift. This step comes before saturation.
- R7: An output component above 32767 is clipped to 32767, and one below −32768 is clipped to −32768. Nothing wraps.
- R8: While `rst_n` is low and for three edges after it rises, `out_valid` is low. Reset clears all output data to zero, and an asynchronous reset in mid-stream discards the beats in flight.
- R9: `dif_sel`, `inv_sel` and `halve_en` are sampled with each beat. Back-to-back beats with different settings are each computed under their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat qualifier for the input samples |
| dif_sel | input | 1 | 1 = frequency-decimation order, 0 = time-decimation order |
| inv_sel | input | 1 | 1 = inverse transform (conjugated twiddle) |
| halve_en | input | 1 | 1 = halve the outputs of this beat |
| a_re | input | 16 | Even sample, real part |
| a_im | input | 16 | Even sample, imaginary part |
| b_re | input | 16 | Odd sample, real part |
| b_im | input | 16 | Odd sample, imaginary part |
| w_re | input | 16 | Twiddle, real part, Q1.15 |
| w_im | input | 16 | Twiddle, imaginary part, Q1.15 |
| out_valid | output | 1 | Result beat qualifier |
| x_re | output | 16 | Upper output, real part |
| x_im | output | 16 | Upper output, imaginary part |
| y_re | output | 16 | Lower output, real part |
| y_im | output | 16 | Lower output, imaginary part |

## Verification
Halving and saturation act on the same result in the same output cycle, and their order matters. A full-scale sum that would clip when unhalved must come out unclipped once halved. This is provoked by streaming corner values (±32767, −32768, ±1) through every combination of the three mode bits, and by directed beats whose sums exceed the 16-bit range. Each output is judged against an integer model in the bench that halves first and clips second. A second collision is a change of decimation order between adjacent beats in flight, which back-to-back directed beats check against literal values.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Per-beat control carried alongside the samples
    typedef struct packed {
        logic dif;    // frequency-decimation ordering
        logic inv;    // conjugate twiddle (inverse transform)
        logic halve;  // scale outputs by one half
    } bfly_mode_t;

endpackage

// File: rtl/bfly_pre.sv
// Stage 1: select operands according to decimation order and conjugate the
// twiddle when the inverse direction is requested.
module bfly_pre
    import bfly_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16,
    localparam int QW = DW + 1,
    localparam int WW = TW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  bfly_mode_t           mode_i,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 vld_o,
    output logic                 dif_o,
    output logic                 halve_o,
    output logic signed [QW-1:0] p_re,
    output logic signed [QW-1:0] p_im,
    output logic signed [QW-1:0] q_re,
    output logic signed [QW-1:0] q_im,
    output logic signed [WW-1:0] wr_o,
    output logic signed [WW-1:0] wi_o
);

    typedef struct packed {
        logic          vld;
        logic          dif;
        logic          halve;
        logic [QW-1:0] pr;
        logic [QW-1:0] pi;
        logic [QW-1:0] qr;
        logic [QW-1:0] qi;
        logic [WW-1:0] wr;
        logic [WW-1:0] wi;
    } pre_st_t;

    pre_st_t st_d, st_q;

    logic signed [QW-1:0] ar_x, ai_x, br_x, bi_x;
    logic signed [WW-1:0] wi_x;

    always_comb begin
        ar_x = {a_re[DW-1], a_re};
        ai_x = {a_im[DW-1], a_im};
        br_x = {b_re[DW-1], b_re};
        bi_x = {b_im[DW-1], b_im};
        wi_x = {w_im[TW-1], w_im};

        st_d.vld   = vld_i;
        st_d.dif   = mode_i.dif;
        st_d.halve = mode_i.halve;

        if (mode_i.dif) begin
            // sum passes straight on, difference goes to the rotator
            st_d.pr = ar_x + br_x;
            st_d.pi = ai_x + bi_x;
            st_d.qr = ar_x - br_x;
            st_d.qi = ai_x - bi_x;
        end else begin
            // even passes on, odd goes to the rotator
            st_d.pr = ar_x;
            st_d.pi = ai_x;
            st_d.qr = br_x;
            st_d.qi = bi_x;
        end

        st_d.wr = {w_re[TW-1], w_re};
        // one extra bit lets -(-2^(TW-1)) stay exact
        st_d.wi = mode_i.inv ? -wi_x : wi_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o   = st_q.vld;
    assign dif_o   = st_q.dif;
    assign halve_o = st_q.halve;
    assign p_re    = st_q.pr;
    assign p_im    = st_q.pi;
    assign q_re    = st_q.qr;
    assign q_im    = st_q.qi;
    assign wr_o    = st_q.wr;
    assign wi_o    = st_q.wi;

    // R4: a conjugated twiddle has the opposite sign of the captured input
    assert_conj_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode_i.inv && (w_im != '0)) |=> (wi_o[WW-1] != $past(w_im[TW-1])));

endmodule

// File: rtl/bfly_cmul.sv
// Stage 2: complex rotation q*w with four signed products, exact sums and
// round-half-up back to integer scale.
module bfly_cmul #(
    parameter int DW = 16,
    parameter int TW = 16,
    localparam int QW  = DW + 1,
    localparam int WW  = TW + 1,
    localparam int PRW = QW + WW,
    localparam int SMW = PRW + 1,
    localparam int SH  = TW - 1,
    localparam int MW  = SMW - SH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic                 dif_i,
    input  logic                 halve_i,
    input  logic signed [QW-1:0] p_re,
    input  logic signed [QW-1:0] p_im,
    input  logic signed [QW-1:0] q_re,
    input  logic signed [QW-1:0] q_im,
    input  logic signed [WW-1:0] w_re,
    input  logic signed [WW-1:0] w_im,
    output logic                 vld_o,
    output logic                 dif_o,
    output logic                 halve_o,
    output logic signed [QW-1:0] p_re_o,
    output logic signed [QW-1:0] p_im_o,
    output logic signed [MW-1:0] m_re,
    output logic signed [MW-1:0] m_im
);

    localparam logic signed [SMW-1:0] RND = SMW'(1) <<< (SH - 1);

    typedef struct packed {
        logic          vld;
        logic          dif;
        logic          halve;
        logic [QW-1:0] pr;
        logic [QW-1:0] pi;
        logic [MW-1:0] mr;
        logic [MW-1:0] mi;
    } mul_st_t;

    mul_st_t st_d, st_q;

    logic signed [PRW-1:0] prod_rr, prod_ii, prod_ri, prod_ir;
    logic signed [SMW-1:0] sum_re, sum_im, rnd_re, rnd_im;

    always_comb begin
        prod_rr = q_re * w_re;
        prod_ii = q_im * w_im;
        prod_ri = q_re * w_im;
        prod_ir = q_im * w_re;

        sum_re = prod_rr - prod_ii;
        sum_im = prod_ri + prod_ir;

        rnd_re = sum_re + RND;
        rnd_im = sum_im + RND;

        st_d.vld   = vld_i;
        st_d.dif   = dif_i;
        st_d.halve = halve_i;
        st_d.pr    = p_re;
        st_d.pi    = p_im;
        st_d.mr    = MW'(rnd_re >>> SH);
        st_d.mi    = MW'(rnd_im >>> SH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o   = st_q.vld;
    assign dif_o   = st_q.dif;
    assign halve_o = st_q.halve;
    assign p_re_o  = st_q.pr;
    assign p_im_o  = st_q.pi;
    assign m_re    = st_q.mr;
    assign m_im    = st_q.mi;

    // R5: a zero operand yields a zero rotated value one edge later
    assert_zero_rotation_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_re == '0 && q_im == '0) |=> (m_re == '0 && m_im == '0));

endmodule

// File: rtl/bfly_post.sv
// Stage 3: form the butterfly outputs, optional halving, then clip to DW bits.
module bfly_post #(
    parameter int DW = 16,
    parameter int TW = 16,
    localparam int QW = DW + 1,
    localparam int MW = DW + 4 + (TW - 16) * 0,
    localparam int SW = MW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic                 dif_i,
    input  logic                 halve_i,
    input  logic signed [QW-1:0] p_re,
    input  logic signed [QW-1:0] p_im,
    input  logic signed [MW-1:0] m_re,
    input  logic signed [MW-1:0] m_im,
    output logic                 vld_o,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] xr;
        logic [DW-1:0] xi;
        logic [DW-1:0] yr;
        logic [DW-1:0] yi;
    } post_st_t;

    post_st_t st_d, st_q;

    function automatic logic signed [SW-1:0] halve_v(input logic signed [SW-1:0] v,
                                                      input logic en);
        return en ? SW'((v + SW'(1)) >>> 1) : v;
    endfunction

    function automatic logic [DW-1:0] clip_v(input logic signed [SW-1:0] v);
        if (v[SW-1:DW-1] == {(SW-DW+1){v[SW-1]}})
            return v[DW-1:0];
        else if (v[SW-1])
            return {1'b1, {(DW-1){1'b0}}};
        else
            return {1'b0, {(DW-1){1'b1}}};
    endfunction

    logic signed [SW-1:0] pe_re, pe_im, me_re, me_im;
    logic signed [SW-1:0] ux_re, ux_im, uy_re, uy_im;

    always_comb begin
        pe_re = {{(SW-QW){p_re[QW-1]}}, p_re};
        pe_im = {{(SW-QW){p_im[QW-1]}}, p_im};
        me_re = {m_re[MW-1], m_re};
        me_im = {m_im[MW-1], m_im};

        if (dif_i) begin
            ux_re = pe_re;
            ux_im = pe_im;
            uy_re = me_re;
            uy_im = me_im;
        end else begin
            ux_re = pe_re + me_re;
            ux_im = pe_im + me_im;
            uy_re = pe_re - me_re;
            uy_im = pe_im - me_im;
        end

        st_d.vld = vld_i;
        st_d.xr  = clip_v(halve_v(ux_re, halve_i));
        st_d.xi  = clip_v(halve_v(ux_im, halve_i));
        st_d.yr  = clip_v(halve_v(uy_re, halve_i));
        st_d.yi  = clip_v(halve_v(uy_im, halve_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign x_re  = st_q.xr;
    assign x_im  = st_q.xi;
    assign y_re  = st_q.yr;
    assign y_im  = st_q.yi;

    // R7: a large positive pre-clip value must leave as the positive limit
    assert_clip_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halve_i && !dif_i && (p_re > 0) && (m_re > 0) && (p_re + m_re > 32767) && (DW == 16))
        |=> (x_re == {1'b0, {(DW-1){1'b1}}}));

endmodule

// File: rtl/fft_bfly_unit.sv
module fft_bfly_unit
    import bfly_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 dif_sel,
    input  logic                 inv_sel,
    input  logic                 halve_en,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);

    localparam int QW = DW + 1;
    localparam int WW = TW + 1;
    localparam int MW = QW + WW + 1 - (TW - 1);

    bfly_mode_t mode_in;
    assign mode_in = '{dif: dif_sel, inv: inv_sel, halve: halve_en};

    logic                 s1_vld, s1_dif, s1_halve;
    logic signed [QW-1:0] s1_pr, s1_pi, s1_qr, s1_qi;
    logic signed [WW-1:0] s1_wr, s1_wi;

    logic                 s2_vld, s2_dif, s2_halve;
    logic signed [QW-1:0] s2_pr, s2_pi;
    logic signed [MW-1:0] s2_mr, s2_mi;

    bfly_pre #(.DW(DW), .TW(TW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (in_valid),
        .mode_i  (mode_in),
        .a_re    (a_re),
        .a_im    (a_im),
        .b_re    (b_re),
        .b_im    (b_im),
        .w_re    (w_re),
        .w_im    (w_im),
        .vld_o   (s1_vld),
        .dif_o   (s1_dif),
        .halve_o (s1_halve),
        .p_re    (s1_pr),
        .p_im    (s1_pi),
        .q_re    (s1_qr),
        .q_im    (s1_qi),
        .wr_o    (s1_wr),
        .wi_o    (s1_wi)
    );

    bfly_cmul #(.DW(DW), .TW(TW)) u_cmul (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (s1_vld),
        .dif_i   (s1_dif),
        .halve_i (s1_halve),
        .p_re    (s1_pr),
        .p_im    (s1_pi),
        .q_re    (s1_qr),
        .q_im    (s1_qi),
        .w_re    (s1_wr),
        .w_im    (s1_wi),
        .vld_o   (s2_vld),
        .dif_o   (s2_dif),
        .halve_o (s2_halve),
        .p_re_o  (s2_pr),
        .p_im_o  (s2_pi),
        .m_re    (s2_mr),
        .m_im    (s2_mi)
    );

    bfly_post #(.DW(DW), .TW(TW)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (s2_vld),
        .dif_i   (s2_dif),
        .halve_i (s2_halve),
        .p_re    (s2_pr),
        .p_im    (s2_pi),
        .m_re    (s2_mr),
        .m_im    (s2_mi),
        .vld_o   (out_valid),
        .x_re    (x_re),
        .x_im    (x_im),
        .y_re    (y_re),
        .y_im    (y_im)
    );

    // Edges seen since reset release, saturating at the pipeline depth;
    // gates properties that look three cycles into the past.
    logic [1:0] since_rst_d, since_rst_q;

    always_comb begin
        since_rst_d = (since_rst_q == 2'd3) ? since_rst_q : since_rst_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst_q <= '0;
        else        since_rst_q <= since_rst_d;
    end

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q != 2'd3) |-> !out_valid);

    assert_dit_unit_rotation_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3 && out_valid && !$past(dif_sel, 3) && !$past(halve_en, 3)
         && $past(w_re, 3) == '0 && $past(w_im, 3) == '0)
        |-> (x_re == $past(a_re, 3) && x_im == $past(a_im, 3)
             && y_re == $past(a_re, 3) && y_im == $past(a_im, 3)));

    assert_dif_sum_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3 && out_valid && $past(dif_sel, 3) && !$past(halve_en, 3)
         && $past(b_re, 3) == '0 && $past(b_im, 3) == '0)
        |-> (x_re == $past(a_re, 3) && x_im == $past(a_im, 3)));

endmodule

// File: tb/fft_bfly_unit_tb.sv
`timescale 1ns/1ps
module fft_bfly_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dif_sel = 1'b0, inv_sel = 1'b0, halve_en = 1'b0;
    logic [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
    logic        out_valid;
    logic [15:0] x_re, x_im, y_re, y_im;

    always #10 clk = ~clk;   // 50 MHz

    fft_bfly_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .dif_sel(dif_sel), .inv_sel(inv_sel), .halve_en(halve_en),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid), .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] exp_q [0:8191];
    logic [2:0]  exp_m [0:8191];
    int          wr_i = 0;
    int          rd_i = 0;
    logic [31:0] lcg  = 32'h1234_5678;

    // ---------------- reference model ----------------
    function automatic longint clip16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint fin(longint v, bit hv);
        if (hv) v = (v + 1) >>> 1;
        return clip16(v);
    endfunction

    function automatic logic [63:0] ref_bfly(logic [15:0] ar, logic [15:0] ai,
                                             logic [15:0] br, logic [15:0] bi,
                                             logic [15:0] wr, logic [15:0] wi,
                                             bit dif, bit inv, bit hv);
        longint a_r = longint'($signed(ar)), a_i = longint'($signed(ai));
        longint b_r = longint'($signed(br)), b_i = longint'($signed(bi));
        longint t_r = longint'($signed(wr)), t_i = longint'($signed(wi));
        longint p_r, p_i, q_r, q_i, m_r, m_i, xr, xi, yr, yi;
        logic [15:0] o0, o1, o2, o3;
        if (inv) t_i = -t_i;
        if (dif) begin
            p_r = a_r + b_r; p_i = a_i + b_i; q_r = a_r - b_r; q_i = a_i - b_i;
        end else begin
            p_r = a_r; p_i = a_i; q_r = b_r; q_i = b_i;
        end
        m_r = (q_r * t_r - q_i * t_i + 16384) >>> 15;
        m_i = (q_r * t_i + q_i * t_r + 16384) >>> 15;
        if (dif) begin xr = p_r; xi = p_i; yr = m_r; yi = m_i; end
        else begin xr = p_r + m_r; xi = p_i + m_i; yr = p_r - m_r; yi = p_i - m_i; end
        o0 = 16'(fin(xr, hv)); o1 = 16'(fin(xi, hv));
        o2 = 16'(fin(yr, hv)); o3 = 16'(fin(yi, hv));
        return {o0, o1, o2, o3};
    endfunction

    function automatic string tag_of(logic [2:0] m);
        string s;
        s = m[2] ? "R3" : "R2";
        if (m[1]) s = {s, " R4"};
        if (m[0]) s = {s, " R6"};
        return {s, " R5 R7"};
    endfunction

    // ---------------- check helper ----------------
    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // ---------------- stimulus ----------------
    task automatic beat(logic [15:0] ar, logic [15:0] ai, logic [15:0] br, logic [15:0] bi,
                        logic [15:0] wr, logic [15:0] wi, bit dif, bit inv, bit hv);
        @(negedge clk);
        in_valid = 1'b1;
        a_re = ar; a_im = ai; b_re = br; b_im = bi; w_re = wr; w_im = wi;
        dif_sel = dif; inv_sel = inv; halve_en = hv;
        exp_q[wr_i % 8192] = ref_bfly(ar, ai, br, bi, wr, wi, dif, inv, hv);
        exp_m[wr_i % 8192] = {dif, inv, hv};
        wr_i++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        a_re = 16'h5A5A; b_re = 16'hA5A5; w_re = 16'h1111;   // junk on idle cycles
    endtask

    function automatic logic [15:0] pick_s(logic [31:0] r);
        case (r[3:0])
            4'd0: return 16'h8000;
            4'd1: return 16'h7FFF;
            4'd2: return 16'h0000;
            4'd3: return 16'hFFFF;
            4'd4: return 16'h0001;
            4'd5: return 16'h8001;
            default: return r[31:16];
        endcase
    endfunction

    function automatic logic [15:0] pick_w(logic [31:0] r);
        case (r[3:0])
            4'd0: return 16'h7FFF;   // ~1
            4'd1: return 16'h8000;   // -1
            4'd2: return 16'h0000;
            4'd3: return 16'h5A82;   // ~1/sqrt2
            4'd4: return 16'hA57E;   // ~-1/sqrt2
            4'd5: return 16'h8001;
            default: return r[31:16];
        endcase
    endfunction

    function automatic logic [31:0] step(logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // ---------------- scoreboard monitor (R1 and datapath) ----------------
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd_i >= wr_i) begin
                check(1'b0, "R1 unexpected out_valid", {63'd0, out_valid}, 64'd0);
            end else begin
                check({x_re, x_im, y_re, y_im} == exp_q[rd_i % 8192],
                      tag_of(exp_m[rd_i % 8192]),
                      {x_re, x_im, y_re, y_im}, exp_q[rd_i % 8192]);
                rd_i++;
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && {x_re, x_im, y_re, y_im} == 64'd0, "R8 reset state",
              {x_re, x_im, y_re, y_im}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: single-beat latency
        beat(16'd10, 16'd20, 16'd0, 16'd0, 16'h7FFF, 16'd0, 1'b0, 1'b0, 1'b0);
        idle();
        check(out_valid == 1'b0, "R1 latency edge1", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 latency edge2", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1 latency edge3", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 single pulse", {63'd0, out_valid}, 64'd0);

        // R5: round-half-up of the product
        beat(16'd0, 16'd0, 16'd1, 16'd0, 16'd16384, 16'd0, 1'b0, 1'b0, 1'b0);
        beat(16'd0, 16'd0, 16'd1, 16'd0, 16'd16383, 16'd0, 1'b0, 1'b0, 1'b0);
        idle();
        @(negedge clk);
        check({x_re, y_re} == {16'd1, 16'hFFFF}, "R5 half rounds up", {32'd0, x_re, y_re},
              {32'd0, 16'd1, 16'hFFFF});
        @(negedge clk);
        check({x_re, y_re} == 32'd0, "R5 below half rounds down", {32'd0, x_re, y_re}, 64'd0);

        // R7: saturation high and low
        beat(16'h7FFF, 16'd0, 16'h7FFF, 16'd0, 16'h7FFF, 16'd0, 1'b0, 1'b0, 1'b0);
        beat(16'h8000, 16'd0, 16'h8000, 16'd0, 16'h7FFF, 16'd0, 1'b0, 1'b0, 1'b0);
        idle();
        @(negedge clk);
        check({x_re, y_re} == {16'h7FFF, 16'd1}, "R7 clip high", {32'd0, x_re, y_re},
              {32'd0, 16'h7FFF, 16'd1});
        @(negedge clk);
        check({x_re, y_re} == {16'h8000, 16'hFFFF}, "R7 clip low", {32'd0, x_re, y_re},
              {32'd0, 16'h8000, 16'hFFFF});

        // R6: halving with rounding; R6 before R7 on a full-scale sum
        beat(16'd3, 16'hFFFD, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 1'b1);
        beat(16'h7FFF, 16'd0, 16'h7FFF, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 1'b1);
        idle();
        @(negedge clk);
        check({x_re, x_im, y_re, y_im} == {16'd2, 16'hFFFF, 32'd0}, "R6 halve rounding",
              {x_re, x_im, y_re, y_im}, {16'd2, 16'hFFFF, 32'd0});
        @(negedge clk);
        check(x_re == 16'h7FFF, "R6 halve before clip", {48'd0, x_re}, {48'd0, 16'h7FFF});

        // R4: conjugated twiddle, including the -32768 imaginary corner
        beat(16'd0, 16'd0, 16'd1000, 16'd0, 16'd0, 16'h7FFF, 1'b0, 1'b0, 1'b0);
        beat(16'd0, 16'd0, 16'd1000, 16'd0, 16'd0, 16'h7FFF, 1'b0, 1'b1, 1'b0);
        beat(16'd0, 16'd0, 16'd1000, 16'd0, 16'd0, 16'h8000, 1'b0, 1'b1, 1'b0);
        idle();
        check({x_re, x_im} == {16'd0, 16'd1000}, "R4 forward", {32'd0, x_re, x_im},
              {32'd0, 16'd0, 16'd1000});
        @(negedge clk);
        check({x_re, x_im} == {16'd0, 16'hFC18}, "R4 inverse", {32'd0, x_re, x_im},
              {32'd0, 16'd0, 16'hFC18});
        @(negedge clk);
        check({x_re, x_im} == {16'd0, 16'd1000}, "R4 negated min twiddle",
              {32'd0, x_re, x_im}, {32'd0, 16'd0, 16'd1000});

        // R9: back-to-back beats with opposite decimation order
        beat(16'd100, 16'd0, 16'd50, 16'd0, 16'd0, 16'h7FFF, 1'b0, 1'b0, 1'b0);
        beat(16'd100, 16'd0, 16'd50, 16'd0, 16'd0, 16'h7FFF, 1'b1, 1'b0, 1'b0);
        idle();
        @(negedge clk);
        check({x_re, x_im, y_re, y_im} == {16'd100, 16'd50, 16'd100, 16'hFFCE},
              "R9 R2 first beat", {x_re, x_im, y_re, y_im},
              {16'd100, 16'd50, 16'd100, 16'hFFCE});
        @(negedge clk);
        check({x_re, x_im, y_re, y_im} == {16'd150, 16'd0, 16'd0, 16'd50},
              "R9 R3 second beat", {x_re, x_im, y_re, y_im},
              {16'd150, 16'd0, 16'd0, 16'd50});

        // Stream: corners and random values, all mode combinations, with bubbles
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] v0, v1, v2, v3, t0, t1;
            lcg = step(lcg); v0 = pick_s(lcg);
            lcg = step(lcg); v1 = pick_s(lcg);
            lcg = step(lcg); v2 = pick_s(lcg);
            lcg = step(lcg); v3 = pick_s(lcg);
            lcg = step(lcg); t0 = pick_w(lcg);
            lcg = step(lcg); t1 = pick_w(lcg);
            beat(v0, v1, v2, v3, t0, t1, i[0], i[1], i[2]);
            if (lcg[9:8] == 2'b00) idle();
        end
        idle();
        repeat (5) @(negedge clk);
        check(rd_i == wr_i, "R1 beat count", 64'(rd_i), 64'(wr_i));

        // R8: asynchronous reset in mid-stream discards beats in flight
        beat(16'd7, 16'd7, 16'd7, 16'd7, 16'h7FFF, 16'd0, 1'b0, 1'b0, 1'b0);
        beat(16'd9, 16'd9, 16'd9, 16'd9, 16'h7FFF, 16'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        rd_i = wr_i;
        #1;
        check(out_valid == 1'b0 && {x_re, x_im, y_re, y_im} == 64'd0, "R8 mid-stream reset",
              {x_re, x_im, y_re, y_im}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R8 flushed beats stay gone", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule